// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block produces memory addresses for indirect access, with circular buffering done in hardware. It contains several independent generator lanes; two by default. Each lane keeps register sets that hold a pointer, a signed step, a buffer size and a buffer start. Every set exists twice, once in a primary bank and once in a secondary bank. A shared bank-select input chooses which bank the lanes read.

A request names a lane's register set and a mode:
- **Post-step mode** returns the current pointer. It then advances the pointer by the step and folds the pointer back into the buffer when it leaves the window [start, start+size).
- **Pre-step mode** returns pointer plus step and leaves the pointer unchanged.

A size of zero turns folding off, and the pointer then moves linearly modulo 2^AW. The buffer may begin at any address and may have any size; there is no alignment constraint. Software loads the sets through a single write port that names the lane, bank, set and field. With the default parameters this gives 32 circular buffers in total: 2 lanes × 2 banks × 8 sets.

Top module: `cbuf_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, every field of every set in both banks is zero, the primary bank is active, `addr_vld` is low and `addr_out` is zero.
- R2: A request presented in cycle n gives `addr_vld` high in cycle n+1. In post-step mode `addr_out` then equals the pointer that the set held in cycle n. With no request, `addr_vld` is low and `addr_out` keeps its last value.
- R3: In post-step mode with size L ≠ 0, start B, pointer I and step M (|M| ≤ L), if I+M ≥ B+L the new pointer is I+M−L. This holds for any B and L, aligned or not.
- R4: In post-step mode with L ≠ 0, if I+M < B the new pointer is I+M+L. Otherwise, when neither fold applies, it is I+M.
- R5: With L = 0 a post-step request sets the pointer to (I+M) mod 2^AW, with no folding.
- R6: A pre-step request outputs (I+M) mod 2^AW one cycle later and leaves the pointer unchanged.
- R7: `bank_sel` (0 = primary, 1 = secondary) is registered. A request made in the cycle the input changes still uses the previous bank, and the next cycle uses the new one. The contents of both banks are kept across switches.
- R8: The lanes act independently. Simultaneous requests on both lanes each see only their own lane's sets.
- R9: A write to the register port is visible to requests from the next cycle on. Field code 0 selects the pointer, 1 the step (two's complement), 2 the size and 3 the start. When a write to a pointer coincides with a post-step update of that same pointer, the written value wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_sel | input | 1 | Bank choice: 0 primary, 1 secondary (registered) |
| wr_en | input | 1 | Register write strobe |
| wr_gen | input | GEN_W | Lane addressed by the write |
| wr_bank | input | 1 | Bank addressed by the write |
| wr_set | input | SET_W | Set addressed by the write |
| wr_field | input | 2 | Field code: 0 pointer, 1 step, 2 size, 3 start |
| wr_data | input | AW | Write data |
| gen_req | input | NUM_GEN | Per-lane request strobe |
| gen_pre | input | NUM_GEN | Per-lane mode: 1 pre-step, 0 post-step |
| gen_set | input | NUM_GEN*SET_W | Per-lane set number; lane g uses bits [g*SET_W +: SET_W] |
| addr_out | output | NUM_GEN*AW | Per-lane registered address; lane g uses bits [g*AW +: AW] |
| addr_vld | output | NUM_GEN | Per-lane address-valid flag |

## Verification
The stimulus contains five directed patterns:
- **Forward step past the end of an unaligned buffer.** This separates the upward fold from plain addition.
- **Negative step below the start.** This exposes a missing downward fold or a wrong sign extension of the step.
- **Zero-size set near the top of the address space.** This shows whether linear mode wraps modulo 2^AW instead of folding.
- **Pre-step requests repeated on one set.** These show whether the pointer is wrongly written back.
- **Bank toggles and same-cycle write/update collisions.** These catch a bank select that is not registered and a wrong write priority.

A randomized phase then mixes modes, sets, banks and simultaneous lane requests against a behavioural model, which shows up any crosstalk between lanes.

// File: rtl/cbuf_pkg.sv
// Package: shared types for the circular-buffer address generator.
// Assumes: two banks per lane (primary/secondary); field codes fixed below.
package cbuf_pkg;

    // Register field selector used on the write port.
    typedef enum logic [1:0] {
        FLD_INDEX  = 2'd0,
        FLD_STEP   = 2'd1,
        FLD_SIZE   = 2'd2,
        FLD_START  = 2'd3
    } cbuf_field_e;

    localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/cbuf_wrap_unit.sv
// Module: cbuf_wrap_unit
// Computes the next pointer value from pointer, signed step, size and start.
// Assumes: |step| <= size when size is non-zero; size zero means linear mode.
// Arithmetic is done two bits wider than AW so comparisons never alias.
module cbuf_wrap_unit #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] cur_idx,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] size,
    input  logic [AW-1:0] start,
    output logic [AW-1:0] next_idx
);
    localparam int unsigned EW = AW + 2;

    logic signed [EW-1:0] sum_x;
    logic signed [EW-1:0] hi_x;
    logic signed [EW-1:0] lo_x;
    logic signed [EW-1:0] size_x;
    logic signed [EW-1:0] res_x;
    logic                 circ;

    // Widen operands: pointer, start and size unsigned; step sign-extended.
    always_comb begin
        sum_x  = $signed({2'b00, cur_idx}) + $signed({{2{step[AW-1]}}, step});
        lo_x   = $signed({2'b00, start});
        size_x = $signed({2'b00, size});
        hi_x   = lo_x + size_x;
        circ   = |size;
    end

    // Fold the advanced pointer back into the window when it leaves it.
    always_comb begin
        if (circ && (sum_x >= hi_x)) begin
            res_x = sum_x - size_x;
        end else if (circ && (sum_x < lo_x)) begin
            res_x = sum_x + size_x;
        end else begin
            res_x = sum_x;
        end
        next_idx = res_x[AW-1:0];
    end

endmodule

// File: rtl/cbuf_regbank.sv
// Module: cbuf_regbank
// Holds pointer, step, size and start for every set of both banks of one lane.
// Assumes: one software write and one pointer update per cycle; when both
// target the same pointer the software write wins. Reads are combinational.
module cbuf_regbank
    import cbuf_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned SETS  = 8,
    parameter int unsigned SET_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [SET_W-1:0]  wr_set,
    input  cbuf_field_e       wr_field,
    input  logic [AW-1:0]     wr_data,
    input  logic              upd_en,
    input  logic              upd_bank,
    input  logic [SET_W-1:0]  upd_set,
    input  logic [AW-1:0]     upd_idx,
    input  logic              rd_bank,
    input  logic [SET_W-1:0]  rd_set,
    output logic [AW-1:0]     rd_idx,
    output logic [AW-1:0]     rd_step,
    output logic [AW-1:0]     rd_size,
    output logic [AW-1:0]     rd_start
);
    logic [AW-1:0] idx_r   [NUM_BANKS][SETS];
    logic [AW-1:0] step_r  [NUM_BANKS][SETS];
    logic [AW-1:0] size_r  [NUM_BANKS][SETS];
    logic [AW-1:0] start_r [NUM_BANKS][SETS];

    // Storage update: clear on reset, then pointer update, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                for (int s = 0; s < SETS; s++) begin
                    idx_r[b][s]   <= '0;
                    step_r[b][s]  <= '0;
                    size_r[b][s]  <= '0;
                    start_r[b][s] <= '0;
                end
            end
        end else begin
            if (upd_en) begin
                idx_r[upd_bank][upd_set] <= upd_idx;
            end
            if (wr_en) begin
                case (wr_field)
                    FLD_INDEX: idx_r[wr_bank][wr_set]   <= wr_data;
                    FLD_STEP:  step_r[wr_bank][wr_set]  <= wr_data;
                    FLD_SIZE:  size_r[wr_bank][wr_set]  <= wr_data;
                    FLD_START: start_r[wr_bank][wr_set] <= wr_data;
                    default:   ;
                endcase
            end
        end
    end

    // Read port for the set named by the current request.
    always_comb begin
        rd_idx   = idx_r[rd_bank][rd_set];
        rd_step  = step_r[rd_bank][rd_set];
        rd_size  = size_r[rd_bank][rd_set];
        rd_start = start_r[rd_bank][rd_set];
    end

endmodule

// File: rtl/cbuf_agen_lane.sv
// Module: cbuf_agen_lane
// One address-generator lane: register sets, fold arithmetic and the
// registered address output with one-cycle latency.
// Assumes: the active bank arrives already registered from the top.
module cbuf_agen_lane
    import cbuf_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned SETS  = 8,
    parameter int unsigned SET_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_bank,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [1:0]        wr_field,
    input  logic [AW-1:0]     wr_data,
    input  logic              req,
    input  logic              pre,
    input  logic [SET_W-1:0]  set,
    output logic [AW-1:0]     addr_out,
    output logic              addr_vld
);
    logic [AW-1:0] rd_idx;
    logic [AW-1:0] rd_step;
    logic [AW-1:0] rd_size;
    logic [AW-1:0] rd_start;
    logic [AW-1:0] nxt_idx;
    logic          post_upd;

    assign post_upd = req && !pre;

    cbuf_regbank #(
        .AW    (AW),
        .SETS  (SETS),
        .SET_W (SET_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_set   (wr_set),
        .wr_field (cbuf_field_e'(wr_field)),
        .wr_data  (wr_data),
        .upd_en   (post_upd),
        .upd_bank (act_bank),
        .upd_set  (set),
        .upd_idx  (nxt_idx),
        .rd_bank  (act_bank),
        .rd_set   (set),
        .rd_idx   (rd_idx),
        .rd_step  (rd_step),
        .rd_size  (rd_size),
        .rd_start (rd_start)
    );

    cbuf_wrap_unit #(
        .AW (AW)
    ) u_wrap (
        .cur_idx  (rd_idx),
        .step     (rd_step),
        .size     (rd_size),
        .start    (rd_start),
        .next_idx (nxt_idx)
    );

    // Output register: current pointer (post-step) or pointer plus step (pre-step).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out <= '0;
            addr_vld <= 1'b0;
        end else begin
            addr_vld <= req;
            if (req) begin
                addr_out <= pre ? (rd_idx + rd_step) : rd_idx;
            end
        end
    end

    // Precondition for the window check: pointer inside window, |step| <= size.
    logic [AW:0] win_hi;
    logic [AW-1:0] step_mag;
    logic        in_window;
    always_comb begin
        win_hi    = {1'b0, rd_start} + {1'b0, rd_size};
        step_mag  = rd_step[AW-1] ? (~rd_step + 1'b1) : rd_step;
        in_window = (rd_size != '0) && (rd_idx >= rd_start) &&
                    ({1'b0, rd_idx} < win_hi) && (step_mag <= rd_size);
    end

    assert_vld_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> addr_vld);

    assert_vld_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !addr_vld);

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(addr_out));

    assert_post_addr_is_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        post_upd |=> (addr_out == $past(rd_idx)));

    assert_wrap_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (post_upd && in_window) |->
            ((nxt_idx >= rd_start) && ({1'b0, nxt_idx} < win_hi)));

endmodule

// File: rtl/cbuf_addr_gen.sv
// Module: cbuf_addr_gen (top)
// Replicates the address-generator lane NUM_GEN times, routes the shared
// write port to the addressed lane and registers the bank selection.
// Assumes: the bank choice applies to all lanes and takes effect one cycle later.
module cbuf_addr_gen #(
    parameter int unsigned AW      = 32,
    parameter int unsigned NUM_GEN = 2,
    parameter int unsigned SETS    = 8,
    localparam int unsigned SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int unsigned GEN_W  = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bank_sel,
    input  logic                       wr_en,
    input  logic [GEN_W-1:0]           wr_gen,
    input  logic                       wr_bank,
    input  logic [SET_W-1:0]           wr_set,
    input  logic [1:0]                 wr_field,
    input  logic [AW-1:0]              wr_data,
    input  logic [NUM_GEN-1:0]         gen_req,
    input  logic [NUM_GEN-1:0]         gen_pre,
    input  logic [NUM_GEN*SET_W-1:0]   gen_set,
    output logic [NUM_GEN*AW-1:0]      addr_out,
    output logic [NUM_GEN-1:0]         addr_vld
);
    logic bank_q;

    // Bank selection register: switch applies from the next cycle on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= 1'b0;
        end else begin
            bank_q <= bank_sel;
        end
    end

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_lane
        logic lane_wr;
        assign lane_wr = wr_en && (wr_gen == GEN_W'(g));

        cbuf_agen_lane #(
            .AW    (AW),
            .SETS  (SETS),
            .SET_W (SET_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_bank (bank_q),
            .wr_en    (lane_wr),
            .wr_bank  (wr_bank),
            .wr_set   (wr_set),
            .wr_field (wr_field),
            .wr_data  (wr_data),
            .req      (gen_req[g]),
            .pre      (gen_pre[g]),
            .set      (gen_set[g*SET_W +: SET_W]),
            .addr_out (addr_out[g*AW +: AW]),
            .addr_vld (addr_vld[g])
        );
    end

    assert_lane_vld_tracks_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (addr_vld == $past(gen_req)));

endmodule

// File: tb/test_cbuf_addr_gen.sv
`timescale 1ns/1ps
module test_cbuf_addr_gen;
    localparam int AW = 32;
    localparam int NG = 2;
    localparam int NS = 8;
    localparam int SW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bank_sel = 1'b0;
    logic            wr_en = 1'b0;
    logic [0:0]      wr_gen = '0;
    logic            wr_bank = 1'b0;
    logic [SW-1:0]   wr_set = '0;
    logic [1:0]      wr_field = '0;
    logic [AW-1:0]   wr_data = '0;
    logic [NG-1:0]   gen_req = '0;
    logic [NG-1:0]   gen_pre = '0;
    logic [NG*SW-1:0] gen_set = '0;
    logic [NG*AW-1:0] addr_out;
    logic [NG-1:0]   addr_vld;

    int checks = 0;
    int fails = 0;
    string cur_tag = "R1";
    bit done = 0;

    always #2.5 clk = ~clk;

    cbuf_addr_gen i_cbuf_addr_gen (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .wr_en(wr_en),
        .wr_gen(wr_gen), .wr_bank(wr_bank), .wr_set(wr_set),
        .wr_field(wr_field), .wr_data(wr_data), .gen_req(gen_req),
        .gen_pre(gen_pre), .gen_set(gen_set), .addr_out(addr_out),
        .addr_vld(addr_vld)
    );

    // Behavioural reference model.
    logic [31:0] m_idx [NG][2][NS];
    logic [31:0] m_stp [NG][2][NS];
    logic [31:0] m_len [NG][2][NS];
    logic [31:0] m_bas [NG][2][NS];
    logic        m_bank;
    logic [31:0] e_addr [NG];
    logic        e_vld  [NG];

    function automatic logic [31:0] fold(logic [31:0] i, logic [31:0] m,
                                         logic [31:0] l, logic [31:0] b);
        longint s;
        s = longint'(i) + longint'($signed(m));
        if (l != 0) begin
            if (s >= longint'(b) + longint'(l)) s = s - longint'(l);
            else if (s < longint'(b)) s = s + longint'(l);
        end
        return s[31:0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NG; g++) begin
                e_addr[g] = 0; e_vld[g] = 0;
                for (int b = 0; b < 2; b++)
                    for (int s = 0; s < NS; s++) begin
                        m_idx[g][b][s] = 0; m_stp[g][b][s] = 0;
                        m_len[g][b][s] = 0; m_bas[g][b][s] = 0;
                    end
            end
            m_bank = 0;
        end else begin
            for (int g = 0; g < NG; g++) begin
                int s;
                s = int'(gen_set[g*SW +: SW]);
                e_vld[g] = gen_req[g];
                if (gen_req[g]) begin
                    if (gen_pre[g]) begin
                        e_addr[g] = m_idx[g][m_bank][s] + m_stp[g][m_bank][s];
                    end else begin
                        e_addr[g] = m_idx[g][m_bank][s];
                        m_idx[g][m_bank][s] = fold(m_idx[g][m_bank][s], m_stp[g][m_bank][s],
                                                   m_len[g][m_bank][s], m_bas[g][m_bank][s]);
                    end
                end
            end
            if (wr_en) begin
                case (wr_field)
                    2'd0: m_idx[wr_gen][wr_bank][wr_set] = wr_data;
                    2'd1: m_stp[wr_gen][wr_bank][wr_set] = wr_data;
                    2'd2: m_len[wr_gen][wr_bank][wr_set] = wr_data;
                    default: m_bas[wr_gen][wr_bank][wr_set] = wr_data;
                endcase
            end
            m_bank = bank_sel;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int g = 0; g < NG; g++) begin
                checks++;
                if (addr_vld[g] !== e_vld[g] || addr_out[g*AW +: AW] !== e_addr[g]) begin
                    fails++;
                    $display("FAIL %s lane%0d: vld=%0b addr=%h expected vld=%0b addr=%h",
                             cur_tag, g, addr_vld[g], addr_out[g*AW +: AW], e_vld[g], e_addr[g]);
                end
            end
        end
    end

    task automatic wr(input int g, input int b, input int s, input int f, input logic [31:0] d);
        wr_en = 1; wr_gen = 1'(g); wr_bank = b[0]; wr_set = SW'(s);
        wr_field = 2'(f); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic prog(input int g, input int b, input int s, input logic [31:0] i,
                        input logic [31:0] m, input logic [31:0] l, input logic [31:0] base);
        wr(g, b, s, 3, base); wr(g, b, s, 2, l); wr(g, b, s, 1, m); wr(g, b, s, 0, i);
    endtask

    task automatic rq(input int g, input int s, input bit pre, input int n);
        for (int k = 0; k < n; k++) begin
            gen_req[g] = 1; gen_pre[g] = pre; gen_set[g*SW +: SW] = SW'(s);
            @(negedge clk);
        end
        gen_req[g] = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state observed at the ports, including zeroed registers.
        cur_tag = "R1";
        checks++;
        if (addr_vld !== '0 || addr_out !== '0) begin
            fails++;
            $display("FAIL R1: vld=%b addr=%h expected vld=0 addr=0", addr_vld, addr_out);
        end
        rq(0, 5, 0, 2);
        rq(1, 7, 1, 1);
        @(negedge clk);

        // R3: forward steps past the end of an unaligned window.
        cur_tag = "R3";
        prog(0, 0, 0, 32'h1003, 32'd3, 32'd10, 32'h1003);
        rq(0, 0, 0, 9);

        // R4: negative step crossing below the start.
        cur_tag = "R4";
        prog(0, 0, 1, 32'h2002, 32'hFFFF_FFFC, 32'd7, 32'h2000);
        rq(0, 1, 0, 8);

        // R2: plain post-step inside a large window, then idle hold.
        cur_tag = "R2";
        prog(1, 0, 3, 32'h500, 32'd16, 32'h1000, 32'h400);
        rq(1, 3, 0, 4);
        repeat (3) @(negedge clk);

        // R5: linear mode near the top of the address space.
        cur_tag = "R5";
        prog(1, 0, 2, 32'hFFFF_FFFE, 32'd3, 32'd0, 32'd0);
        rq(1, 2, 0, 3);

        // R6: pre-step repeated, pointer must stay put; then a post-step shows it.
        cur_tag = "R6";
        rq(1, 2, 1, 3);
        rq(1, 2, 0, 1);
        rq(0, 0, 1, 2);

        // R7: bank switch, same-cycle request uses old bank; primary preserved.
        cur_tag = "R7";
        prog(0, 1, 0, 32'h8000_0001, 32'd5, 32'd11, 32'h8000_0000);
        bank_sel = 1;
        rq(0, 0, 0, 1);
        rq(0, 0, 0, 4);
        bank_sel = 0;
        rq(0, 0, 0, 3);
        bank_sel = 1;
        @(negedge clk);
        rq(0, 0, 1, 1);
        bank_sel = 0;
        @(negedge clk);

        // R8: both lanes at once on the same set number.
        cur_tag = "R8";
        prog(1, 0, 0, 32'h3000, 32'd2, 32'd5, 32'h2FFF);
        for (int k = 0; k < 6; k++) begin
            gen_req = 2'b11; gen_pre = 2'(k % 3 == 2 ? 2'b01 : 2'b00); gen_set = '0;
            @(negedge clk);
        end
        gen_req = 0;

        // R9: write collides with post-step update of the same pointer.
        cur_tag = "R9";
        gen_req[0] = 1; gen_pre[0] = 0; gen_set[0 +: SW] = 0;
        wr(0, 0, 0, 0, 32'h100A);
        gen_req[0] = 0;
        rq(0, 0, 0, 2);
        wr(0, 0, 1, 1, 32'd2);
        rq(0, 1, 0, 3);

        // Mixed random traffic over programmed sets.
        cur_tag = "R8";
        for (int k = 0; k < 300; k++) begin
            gen_req  = 2'($urandom);
            gen_pre  = 2'($urandom);
            gen_set  = {SW'($urandom_range(0, 3)), SW'($urandom_range(0, 3))};
            bank_sel = 1'($urandom);
            @(negedge clk);
        end
        gen_req = 0;
        repeat (2) @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule